// File: doc/BRIEF.md
# Projective-plane pair-to-line assigner

This unit picks the processor that owns a two-operand operation in a machine whose memory modules are the points and whose processors are the lines of a finite projective plane of order `S`. The plane has `N = S*S + S + 1` points and the same number of lines. Each line holds `S+1` points, and each point lies on `S+1` lines. Two distinct points share exactly one line, so the operation on those two operands goes to the processor numbered by that line.

The plane is used in its cyclic form. A base line `D` is a perfect difference set modulo `N`, given as a parameter table. Line `k` is the set `{(d + k) mod N : d in D}`. For distinct points `a` and `b` the unit finds the one ordered pair `(d1, d2)` of base elements with `d2 - d1 = b - a (mod N)` and returns `k = (a - d1) mod N`. When the two points are equal the choice is free, and the unit returns a fixed default. A request is a strobe with two point indices. The answer is registered and appears one cycle later.

Top module: `pl_pair_line_assigner`

## Requirements
- R1: While reset is high, and in the cycle after it is released with no request, `vld_o`, `err_o` and `same_o` are 0 and `line_o` is 0.
- R2: A request with both indices below `N` gives `vld_o = 1` exactly one clock edge later. A cycle with `vld_i = 0` gives `vld_o = 0` and `err_o = 0` after the next edge.
- R3: For distinct in-range points `a` and `b`, `line_o` is a line that contains both points. Line `k` contains point `p` exactly when `(p - k) mod N` is an element of the base set (default `S = 2`: base set {0,1,3}, `N = 7`).
- R4: The result does not depend on operand order: `(a,b)` and `(b,a)` give the same line. Across all unordered pairs of distinct points, each line is returned for exactly `S*(S+1)/2` pairs.
- R5: For equal in-range points `a = b`, `same_o = 1` and `line_o = (a - D[0]) mod N`. This is the shift of the base line whose first element is `a` (default: `line_o = a`).
- R6: If either index is `N` or greater, `err_o = 1` one edge later, and `vld_o`, `same_o` and `line_o` are 0.
- R7: For distinct in-range points `same_o = 0`.
- R8: Requests on consecutive cycles each produce their own result on the following cycle, in order and with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Request strobe |
| pt_a_i | input | W = $clog2(N) | First point index |
| pt_b_i | input | W | Second point index |
| vld_o | output | 1 | Result valid (registered) |
| line_o | output | W | Line (processor) index |
| same_o | output | 1 | The two points were equal |
| err_o | output | 1 | An index was out of range |

## Verification
Every result is due after exactly one rising edge. The bench drives a request at a falling edge and samples all four outputs one time unit after the next rising edge, which is still before the next falling edge. A request issued on every cycle therefore has its own sampling slot, so back-to-back traffic is checked with the same timing as single requests. The line returned is checked by a brute-force search for the line that holds both points. A count per line over all distinct pairs confirms that each pair maps to exactly one line.

// File: rtl/pl_pkg.sv
package pl_pkg;
  // (x - y) mod n for operands already reduced below n
  function automatic int unsigned mod_sub(input int unsigned x, input int unsigned y,
                                          input int unsigned n);
    return (x >= y) ? (x - y) : (x + n - y);
  endfunction

  function automatic int unsigned plane_size(input int unsigned order);
    return order * order + order + 1;
  endfunction
endpackage

// File: rtl/pl_range_gate.sv
module pl_range_gate #(
  parameter int unsigned N = 7,
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] pt_a,
  input  logic [W-1:0] pt_b,
  output logic         in_range,
  output logic         same_pt
);
  assign in_range = (32'(pt_a) < N) && (32'(pt_b) < N);
  assign same_pt  = (pt_a == pt_b);
endmodule

// File: rtl/pl_line_solver.sv
module pl_line_solver
  import pl_pkg::*;
#(
  parameter int unsigned N    = 7,
  parameter int unsigned K    = 3,
  parameter int unsigned W    = 3,
  parameter logic [K*W-1:0] BASE = {3'd3, 3'd1, 3'd0}
) (
  input  logic [W-1:0]   pt_a,
  input  logic [W-1:0]   pt_b,
  output logic [K*K-1:0] pair_hit,
  output logic [W-1:0]   line_pair,
  output logic [W-1:0]   line_self
);
  localparam int unsigned PAIRS = K * K;

  logic [W-1:0] cand [PAIRS];
  logic [W-1:0] step_ab;

  assign step_ab = W'(mod_sub(32'(pt_b), 32'(pt_a), N));

  // equal points: shift whose first base element lands on the point
  assign line_self = W'(mod_sub(32'(pt_a), 32'(BASE[0 +: W]), N));

  for (genvar i = 0; i < K; i++) begin : g_first
    for (genvar j = 0; j < K; j++) begin : g_second
      localparam int unsigned IDX = i * K + j;
      if (i == j) begin : g_diag
        assign pair_hit[IDX] = 1'b0;
        assign cand[IDX]     = '0;
      end else begin : g_off
        localparam int unsigned GAP =
          mod_sub(32'(BASE[j*W +: W]), 32'(BASE[i*W +: W]), N);
        assign pair_hit[IDX] = (32'(step_ab) == GAP);
        assign cand[IDX]     = pair_hit[IDX]
                             ? W'(mod_sub(32'(pt_a), 32'(BASE[i*W +: W]), N))
                             : '0;
      end
    end
  end

  // perfect difference set: at most one candidate is non-masked
  always_comb begin
    line_pair = '0;
    for (int p = 0; p < PAIRS; p++) line_pair = line_pair | cand[p];
  end
endmodule

// File: rtl/pl_pair_line_assigner.sv
module pl_pair_line_assigner
  import pl_pkg::*;
#(
  parameter int unsigned S    = 2,
  parameter int unsigned N    = plane_size(S),
  parameter int unsigned K    = S + 1,
  parameter int unsigned W    = $clog2(N),
  parameter logic [K*W-1:0] BASE = {3'd3, 3'd1, 3'd0}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] pt_a_i,
  input  logic [W-1:0] pt_b_i,
  output logic         vld_o,
  output logic [W-1:0] line_o,
  output logic         same_o,
  output logic         err_o
);
  logic           in_range;
  logic           same_pt;
  logic [K*K-1:0] pair_hit;
  logic [W-1:0]   line_pair;
  logic [W-1:0]   line_self;
  logic [W-1:0]   line_next;
  logic           accept;
  logic           reject;

  pl_range_gate #(.N(N), .W(W)) u_gate (
    .pt_a(pt_a_i), .pt_b(pt_b_i), .in_range(in_range), .same_pt(same_pt)
  );

  pl_line_solver #(.N(N), .K(K), .W(W), .BASE(BASE)) u_solver (
    .pt_a(pt_a_i), .pt_b(pt_b_i), .pair_hit(pair_hit),
    .line_pair(line_pair), .line_self(line_self)
  );

  assign accept    = vld_i && in_range;
  assign reject    = vld_i && !in_range;
  assign line_next = same_pt ? line_self : line_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
      same_o <= 1'b0;
      line_o <= '0;
    end else begin
      vld_o  <= accept;
      err_o  <= reject;
      same_o <= accept && same_pt;
      line_o <= accept ? line_next : '0;
    end
  end
endmodule

// File: rtl/pl_assigner_chk.sv
module pl_assigner_chk #(
  parameter int unsigned N = 7,
  parameter int unsigned K = 3,
  parameter int unsigned W = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           vld_i,
  input logic [W-1:0]   pt_a_i,
  input logic [W-1:0]   pt_b_i,
  input logic           vld_o,
  input logic [W-1:0]   line_o,
  input logic           same_o,
  input logic           err_o,
  input logic           in_range,
  input logic [K*K-1:0] pair_hit
);
  // R2
  result_due_chk: assert property (@(posedge clk) disable iff (rst)
    vld_i && in_range |=> vld_o && !err_o);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o && !err_o);
  // R6
  bad_index_chk: assert property (@(posedge clk) disable iff (rst)
    vld_i && !in_range |=> err_o && !vld_o && !same_o && line_o == '0);
  // R5
  same_flag_chk: assert property (@(posedge clk) disable iff (rst)
    vld_i && in_range |=> same_o == ($past(pt_a_i) == $past(pt_b_i)));
  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    in_range && pt_a_i != pt_b_i |-> $countones(pair_hit) == 1);
  // R7
  no_match_equal_chk: assert property (@(posedge clk) disable iff (rst)
    pt_a_i == pt_b_i |-> pair_hit == '0);
  // R3
  line_bound_chk: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> 32'(line_o) < N);
endmodule

bind pl_pair_line_assigner pl_assigner_chk #(.N(N), .K(K), .W(W)) u_chk (
  .clk(clk), .rst(rst), .vld_i(vld_i), .pt_a_i(pt_a_i), .pt_b_i(pt_b_i),
  .vld_o(vld_o), .line_o(line_o), .same_o(same_o), .err_o(err_o),
  .in_range(in_range), .pair_hit(pair_hit)
);

// File: tb/pl_pair_line_assigner_bench.sv
module pl_pair_line_assigner_bench;
  localparam int N = 7;
  localparam int K = 3;
  localparam int W = 3;
  localparam int BD [K] = '{0, 1, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vld_i = 1'b0;
  logic [W-1:0] pt_a_i = '0;
  logic [W-1:0] pt_b_i = '0;
  logic vld_o, same_o, err_o;
  logic [W-1:0] line_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int tbl [N][N];
  int per_line [N];

  always #5 clk = ~clk;

  pl_pair_line_assigner u_pl_pair_line_assigner (
    .clk(clk), .rst(rst), .vld_i(vld_i), .pt_a_i(pt_a_i), .pt_b_i(pt_b_i),
    .vld_o(vld_o), .line_o(line_o), .same_o(same_o), .err_o(err_o)
  );

  function automatic bit on_line(input int p, input int k);
    for (int i = 0; i < K; i++) if ((BD[i] + k) % N == p) return 1;
    return 0;
  endfunction

  function automatic int want_line(input int a, input int b);
    if (a == b) return (a - BD[0] + N) % N;
    for (int k = 0; k < N; k++) if (on_line(a, k) && on_line(b, k)) return k;
    return -1;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input bit v, input string tag,
                       output int got_line);
    @(negedge clk);
    vld_i = v; pt_a_i = W'(a); pt_b_i = W'(b);
    @(posedge clk); #1;
    got_line = int'(line_o);
    if (!v) begin
      check({tag, " R2 idle vld"}, int'(vld_o), 0);
      check({tag, " R2 idle err"}, int'(err_o), 0);
    end else if (a >= N || b >= N) begin
      check("R6 err", int'(err_o), 1);
      check("R6 vld", int'(vld_o), 0);
      check("R6 line/same", int'(line_o) + int'(same_o), 0);
    end else begin
      check({tag, " R2 vld"}, int'(vld_o), 1);
      check({tag, " R2 err"}, int'(err_o), 0);
      if (a == b) begin
        check("R5 same", int'(same_o), 1);
        check("R5 line", got_line, want_line(a, b));
      end else begin
        check("R7 same", int'(same_o), 0);
        check("R3 line", got_line, want_line(a, b));
        check("R3 both on line", int'(on_line(a, got_line) && on_line(b, got_line)), 1);
      end
    end
  endtask

  initial begin
    int ln;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 vld", int'(vld_o), 0);
    check("R1 err", int'(err_o), 0);
    check("R1 same", int'(same_o), 0);
    check("R1 line", int'(line_o), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after release", int'(vld_o) + int'(err_o), 0);

    // exhaustive, back to back (R8)
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        drive(a, b, 1'b1, "R8", ln);
        tbl[a][b] = ln;
      end
    for (int k = 0; k < N; k++) per_line[k] = 0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++) begin
        check("R4 order", tbl[b][a], tbl[a][b]);
        per_line[tbl[a][b]]++;
      end
    for (int k = 0; k < N; k++) check("R4 pairs per line", per_line[k], K * (K - 1) / 2);

    // directed corners
    drive(N, 0, 1'b1, "R6", ln);
    drive(0, N, 1'b1, "R6", ln);
    drive(3, 3, 1'b0, "R2", ln);
    drive(6, 6, 1'b1, "R5", ln);
    drive(6, 0, 1'b1, "R3", ln);

    // random mix
    for (int t = 0; t < 300; t++) begin
      int a, b;
      a = int'($urandom_range(N));
      b = ($urandom_range(3) == 0) ? a : int'($urandom_range(N));
      drive(a, b, ($urandom_range(4) != 0), "R2", ln);
    end
    @(negedge clk); vld_i = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule